// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the byte a host sees when it reads a flash device while an internal program or erase is running, waiting in its sector-collection window, or suspended. Outside those conditions, and for addresses an operation does not cover, it passes the array data through unchanged. It also drives an active-low ready/busy line.

The command decoder supplies the current operation state, a fail flag, the byte being programmed, the mask of sectors selected for erase and a flag saying whether the target of a program is protected. The read path supplies a read strobe, the sector index of the read address, a flag that the read address equals the address being programmed, and the raw array byte. Two toggle flip-flops advance on the rising edge of the read strobe, which is sampled on the system clock. The first toggles on any read while an operation is active. The second toggles only on reads of sectors selected for erase. A program aimed at a protected sector shows busy status for a fixed number of clocks and then returns to array data.

Top module: `opStatusReporter`

## Requirements
- R1: With `opState` = 0 (idle), `rdData` equals `arrayData` and `busyN` is 1.
- R2: With `opState` = 1 (program, unprotected target), the status byte is bit7 = NOT `progData[7]`, bit6 = toggle, bit5 = `opFail`, bit3 = 0, bit2 = 1, and bits 4, 1 and 0 are 0. `busyN` is 0.
- R3: With `opState` = 2 (erase window) or 3 (erasing), bit7 is 0, bit5 is `opFail` and bits 4, 1 and 0 are 0. Bit3 is 0 in the window and 1 while erasing. `busyN` is 0.
- R4: Each read-strobe rising edge seen in states 1, 2, 3 or 5 inverts bit6 for the following reads, whatever the address. Bit6 reads 0 on the first read after leaving state 0.
- R5: In every status byte of states 1, 2, 3 and 5, bit5 equals `opFail`.
- R6: In states 2 to 5, bit2 inverts on each read-strobe rising edge whose sector has its `eraseMask` bit set. Reads of unselected sectors leave bit2 unchanged, and those reads show bit2 = 1.
- R7: With `opState` = 4 (suspended, read), a read of a selected sector returns bit7 = 1, bit6 = 1, the bit2 toggle and all other bits 0. A read of any other sector returns `arrayData`. `busyN` is 1.
- R8: With `opState` = 5 (suspended, program), bit7 = NOT `progData[7]`, bit6 toggles and `busyN` is 0. When `rdProgAddr` is 1, bit2 reads 1 and does not toggle.
- R9: In state 1 with `progProt` = 1, status (as in R2) is shown for the first `PROT_CYCLES` clocks after leaving state 0. After that, `rdData` equals `arrayData`, `busyN` is 1 and bit6 no longer advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdStrobe | input | 1 | Read strobe; its rising edge marks one read |
| rdSector | input | SECT_W | Sector index of the read address |
| rdProgAddr | input | 1 | Read address equals the address being programmed |
| opState | input | 3 | 0 idle, 1 program, 2 erase window, 3 erasing, 4 suspend read, 5 suspend program |
| opFail | input | 1 | Operation exceeded its internal limit |
| progProt | input | 1 | Program target lies in a protected sector |
| progData | input | 8 | Byte being programmed |
| eraseMask | input | NUM_SECTORS | Sectors selected for erase |
| arrayData | input | 8 | Raw array byte at the read address |
| rdData | output | 8 | Byte returned to the host |
| busyN | output | 1 | Ready (1) / busy (0) |

## Verification
The hardest case is the end of the protected-program window. The counter has to expire while reads keep arriving, and a later read must show that bit6 froze instead of advancing. The bench holds the program state with the protected flag set for longer than `PROT_CYCLES` clocks and issues strobes across the expiry point. A second difficult case is the toggle of bit2 during suspend-program. The bench interleaves reads of selected sectors, unselected sectors and the programmed address, so that the mask gating and the address gating are each exercised against the other. A long random phase then changes state, sector, mask and strobe freely, while a behavioural model is compared against the outputs on every clock.

// File: rtl/opStatusPkg.sv
package opStatusPkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PROG     = 3'd1,
    ST_ERASEWIN = 3'd2,
    ST_ERASE    = 3'd3,
    ST_SUSPRD   = 3'd4,
    ST_SUSPPROG = 3'd5
  } opState_e;

  typedef struct packed {
    logic showStatus;
    logic busy;
    logic tog6;
    logic tog2;
    logic tog2Sel;
  } ctrlFlags_t;

endpackage

// File: rtl/statusCtrl.sv
module statusCtrl
  import opStatusPkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int PROT_CYCLES = 100,
  localparam int SECT_W = $clog2(NUM_SECTORS),
  localparam int CNT_W = $clog2(PROT_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rdStrobe,
  input  logic [SECT_W-1:0]      rdSector,
  input  logic                   rdProgAddr,
  input  opState_e               state,
  input  logic                   progProt,
  input  logic [NUM_SECTORS-1:0] eraseMask,
  output ctrlFlags_t             flags
);

  logic strobeQ;
  logic tog6Q, tog2Q;
  logic [CNT_W-1:0] protCnt;
  logic rdEdge, secSel, protLive, progShown, run6, run2, t2Sel;

  assign rdEdge    = rdStrobe && !strobeQ;
  assign secSel    = eraseMask[rdSector];
  assign protLive  = (protCnt < CNT_W'(PROT_CYCLES));
  assign progShown = (state == ST_PROG) && (!progProt || protLive);
  assign t2Sel     = secSel && !((state == ST_SUSPPROG) && rdProgAddr);

  always_comb begin
    run6 = progShown || (state == ST_ERASEWIN) || (state == ST_ERASE) ||
           (state == ST_SUSPPROG);
    run2 = t2Sel && ((state == ST_ERASEWIN) || (state == ST_ERASE) ||
                     (state == ST_SUSPRD) || (state == ST_SUSPPROG));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ <= 1'b0;
      tog6Q   <= 1'b0;
      tog2Q   <= 1'b0;
      protCnt <= '0;
    end else begin
      strobeQ <= rdStrobe;
      if (state == ST_IDLE) begin
        tog6Q   <= 1'b0;
        tog2Q   <= 1'b0;
        protCnt <= '0;
      end else begin
        if (rdEdge && run6) tog6Q <= !tog6Q;
        if (rdEdge && run2) tog2Q <= !tog2Q;
        if ((state == ST_PROG) && progProt && protLive) protCnt <= protCnt + 1'b1;
      end
    end
  end

  always_comb begin
    flags.tog6       = tog6Q;
    flags.tog2       = tog2Q;
    flags.tog2Sel    = t2Sel;
    flags.busy       = run6;
    flags.showStatus = run6 || ((state == ST_SUSPRD) && secSel);
  end

  // R4: a read edge in an active state inverts the bit6 toggle
  assert_tog6_flip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEdge && run6 && state != ST_IDLE) |=> (tog6Q != $past(tog6Q)));

  // R4: without a read edge an active state keeps bit6
  assert_tog6_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEdge && state != ST_IDLE) |=> $stable(tog6Q));

  // R6: bit2 only moves on a read edge
  assert_tog2_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEdge && state != ST_IDLE) |=> $stable(tog2Q));

  // R9: the protected-program counter stops at its limit
  assert_prot_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    protCnt <= CNT_W'(PROT_CYCLES));

endmodule

// File: rtl/statusPath.sv
module statusPath
  import opStatusPkg::*;
(
  input  opState_e   state,
  input  ctrlFlags_t flags,
  input  logic       opFail,
  input  logic [7:0] progData,
  input  logic [7:0] arrayData,
  output logic [7:0] rdData,
  output logic       busyN
);

  logic bit2;

  assign bit2  = flags.tog2Sel ? flags.tog2 : 1'b1;
  assign busyN = !flags.busy;

  always_comb begin
    rdData = arrayData;
    if (flags.showStatus) begin
      unique case (state)
        ST_PROG:     rdData = {!progData[7], flags.tog6, opFail, 1'b0, 1'b0, 1'b1, 2'b00};
        ST_ERASEWIN: rdData = {1'b0, flags.tog6, opFail, 1'b0, 1'b0, bit2, 2'b00};
        ST_ERASE:    rdData = {1'b0, flags.tog6, opFail, 1'b0, 1'b1, bit2, 2'b00};
        ST_SUSPRD:   rdData = {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, bit2, 2'b00};
        ST_SUSPPROG: rdData = {!progData[7], flags.tog6, opFail, 1'b0, 1'b0, bit2, 2'b00};
        default:     rdData = arrayData;
      endcase
    end
  end

  // R1: idle passes array data and reports ready
  always_comb begin
    if (state == ST_IDLE) begin
      assert_idle_pass_R1: assert (rdData == arrayData && busyN);
    end
  end

  // R3: erase states report bit7 low and busy
  always_comb begin
    if (state == ST_ERASE || state == ST_ERASEWIN) begin
      assert_erase_bit7_R3: assert (rdData[7] == 1'b0 && !busyN);
    end
  end

endmodule

// File: rtl/opStatusReporter.sv
module opStatusReporter
  import opStatusPkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int PROT_CYCLES = 100,
  localparam int SECT_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rdStrobe,
  input  logic [SECT_W-1:0]      rdSector,
  input  logic                   rdProgAddr,
  input  logic [2:0]             opState,
  input  logic                   opFail,
  input  logic                   progProt,
  input  logic [7:0]             progData,
  input  logic [NUM_SECTORS-1:0] eraseMask,
  input  logic [7:0]             arrayData,
  output logic [7:0]             rdData,
  output logic                   busyN
);

  opState_e   state;
  ctrlFlags_t flags;

  assign state = opState_e'(opState);

  statusCtrl #(.NUM_SECTORS(NUM_SECTORS), .PROT_CYCLES(PROT_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdSector(rdSector),
    .rdProgAddr(rdProgAddr), .state(state), .progProt(progProt),
    .eraseMask(eraseMask), .flags(flags)
  );

  statusPath uPath (
    .state(state), .flags(flags), .opFail(opFail), .progData(progData),
    .arrayData(arrayData), .rdData(rdData), .busyN(busyN)
  );

  // R7: suspended reads outside the selected sectors see array data and ready
  assert_susp_other_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opState == 3'd4 && !eraseMask[rdSector]) |-> (rdData == arrayData && busyN));

  // R8: suspend-program read at the programmed address shows bit2 high
  assert_suspprog_bit2_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opState == 3'd5 && rdProgAddr) |-> (rdData[2] && !busyN));

endmodule

// File: tb/opStatusReporter_test.sv
module opStatusReporter_test;

  localparam int CLK_PERIOD = 10;
  localparam int NSEC = 16;
  localparam int PROT = 100;
  localparam int SW = $clog2(NSEC);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStrobe = 1'b0;
  logic [SW-1:0] rdSector = '0;
  logic rdProgAddr = 1'b0;
  logic [2:0] opState = 3'd0;
  logic opFail = 1'b0;
  logic progProt = 1'b0;
  logic [7:0] progData = 8'h00;
  logic [NSEC-1:0] eraseMask = '0;
  logic [7:0] arrayData = 8'h00;
  wire  [7:0] rdData;
  wire        busyN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  opStatusReporter #(.NUM_SECTORS(NSEC), .PROT_CYCLES(PROT)) uut (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdSector(rdSector),
    .rdProgAddr(rdProgAddr), .opState(opState), .opFail(opFail),
    .progProt(progProt), .progData(progData), .eraseMask(eraseMask),
    .arrayData(arrayData), .rdData(rdData), .busyN(busyN)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  // behavioural reference state
  int mPrev = 0, mT6 = 0, mT2 = 0, mCnt = 0;

  function automatic bit selNow();
    return eraseMask[rdSector] && !(opState == 3'd5 && rdProgAddr);
  endfunction

  task automatic expected(output logic [7:0] d, output logic b, output string tag);
    int bit2;
    bit2 = selNow() ? mT2 : 1;
    d = arrayData; b = 1'b1; tag = "R1";
    case (opState)
      3'd1: if (!progProt || mCnt < PROT) begin
              d = {!progData[7], mT6[0], opFail, 2'b00, 1'b1, 2'b00}; b = 1'b0;
              tag = progProt ? "R9" : "R2";
            end else tag = "R9";
      3'd2: begin d = {1'b0, mT6[0], opFail, 2'b00, bit2[0], 2'b00}; b = 1'b0; tag = "R3"; end
      3'd3: begin d = {1'b0, mT6[0], opFail, 1'b0, 1'b1, bit2[0], 2'b00}; b = 1'b0; tag = "R3"; end
      3'd4: begin tag = "R7";
              if (eraseMask[rdSector]) d = {2'b11, 3'b000, bit2[0], 2'b00};
            end
      3'd5: begin d = {!progData[7], mT6[0], opFail, 2'b00, bit2[0], 2'b00}; b = 1'b0; tag = "R8"; end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    logic [7:0] ed; logic eb; string tag;
    if (!rstN) begin
      mPrev = 0; mT6 = 0; mT2 = 0; mCnt = 0;
    end else begin
      int edge_, run6, run2;
      edge_ = rdStrobe && !mPrev;
      mPrev = rdStrobe;
      if (opState == 3'd0) begin
        mT6 = 0; mT2 = 0; mCnt = 0;
      end else begin
        run6 = (opState == 3'd2 || opState == 3'd3 || opState == 3'd5 ||
                (opState == 3'd1 && (!progProt || mCnt < PROT)));
        run2 = (opState >= 3'd2 && opState <= 3'd5) && selNow();
        if (edge_ && run6) mT6 = 1 - mT6;   // R4
        if (edge_ && run2) mT2 = 1 - mT2;   // R6
        if (opState == 3'd1 && progProt && mCnt < PROT) mCnt++;
      end
    end
    #(CLK_PERIOD/4);
    if (!done) begin
      expected(ed, eb, tag);
      checks++;
      if (rdData !== ed || busyN !== eb) begin
        errors++;
        $display("FAIL %s state=%0d: rdData=%h busyN=%b expected rdData=%h busyN=%b",
                 tag, opState, rdData, busyN, ed, eb);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doRead(int sec, bit pa);
    @(negedge clk); rdStrobe = 1'b1; rdSector = SW'(sec); rdProgAddr = pa;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  task automatic directCheck(string tag, logic [7:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s directed: rdData=%h expected %h", tag, rdData, exp);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    arrayData = 8'h5A;
    idle(1);
    directCheck("R1", 8'h5A);          // reset state passes array data
    rstN = 1'b1;
    idle(2);
    // R1: idle passthrough with strobes
    arrayData = 8'h3C; doRead(2, 0); doRead(7, 0);
    // R2/R4/R5: program, bit7 complement, toggling, fail
    progData = 8'h80; opState = 3'd1; idle(1);
    directCheck("R4", 8'b0100_0100 ^ 8'h40); // first read: bit6 0, bit7 = 0
    doRead(3, 0); doRead(9, 0); doRead(9, 0);
    opFail = 1'b1; doRead(1, 0); opFail = 1'b0;
    progData = 8'h11; doRead(4, 0);
    opState = 3'd0; idle(2);
    // R3/R6: erase window then erasing, mixed sectors
    eraseMask = 16'h0012; opState = 3'd2; idle(1);
    doRead(1, 0); doRead(4, 0); doRead(0, 0); doRead(1, 0); doRead(4, 0);
    opState = 3'd3;
    doRead(1, 0); doRead(2, 0); opFail = 1'b1; doRead(4, 0); opFail = 1'b0;
    // R7: suspend read
    opState = 3'd4; arrayData = 8'hA7;
    doRead(1, 0); doRead(5, 0); doRead(4, 0); doRead(15, 0);
    // R8: suspend program with programmed address reads
    opState = 3'd5; progData = 8'h7F;
    doRead(6, 1); doRead(6, 1); doRead(1, 0); doRead(8, 0); doRead(4, 0);
    opState = 3'd4; doRead(1, 0);
    opState = 3'd3; doRead(4, 0);
    opState = 3'd0; idle(2);
    // R9: protected program window and expiry
    progProt = 1'b1; progData = 8'h00; opState = 3'd1; arrayData = 8'h96;
    repeat (60) doRead(3, 0);
    repeat (5) doRead(3, 0);
    idle(3);
    directCheck("R9", 8'h96);
    opState = 3'd0; progProt = 1'b0; idle(2);
    // random phase across all states
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 24) == 0) opState = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 40) == 0) eraseMask = NSEC'($urandom);
      if ($urandom_range(0, 60) == 0) progProt = $urandom_range(0, 1);
      rdStrobe   = $urandom_range(0, 1);
      rdSector   = SW'($urandom);
      rdProgAddr = ($urandom_range(0, 3) == 0);
      opFail     = ($urandom_range(0, 7) == 0);
      progData   = 8'($urandom);
      arrayData  = 8'($urandom);
    end
    @(negedge clk); rdStrobe = 1'b0; opState = 3'd0;
    idle(3);
    finishRun();
  end

endmodule